// File: doc/BRIEF.md
# Read-Triggered Serial Master Receiver

This block is a serial bus master that only receives. It drives the serial clock, samples a serial data input, and builds words of 8 to 15 bits. The host never writes to start a transfer. Each transfer begins when the host reads the receive data word. The first such read after enabling returns a word with no meaning, because nothing has been received yet. When a transfer completes, the block loads the receive word and pulses an interrupt.

In continuous reception, the host reads the receive word after every interrupt. That read returns the finished word and also launches the next transfer. To end a stream, the host first clears a start-control bit. The last read then only collects the final word. After that, the host waits for the busy flag to read 0 and then switches the block off.

The register interface has a control word, the receive word and a status word. The control word holds run, receive-enable, transmit-enable, start-control, bit-order and length. The clock rate is the system clock divided by 2·`HALF_DIV`. The serial output is held low.

Top module: `rxm_top`

## Requirements
- R1: While the run bit (control bit 0) is 0, the block is stopped. Status bit 0 reads 0 and `sck_o` stays high. A read of the receive word (address 1) starts no transfer, and the receive word reads 0 one cycle after run is 0.
- R2: The receive-enable (bit 1), transmit-enable (bit 2), bit-order (bit 4) and length (bits 7:5) fields are written only when run is 0 before the write. A write while run is 1 leaves them unchanged. Run (bit 0) and start-control (bit 3) can be written at any time. The control word reads back at address 0.
- R3: A read of address 1 starts a transfer only when run=1, receive-enable=1, transmit-enable=0, start-control=1 and the block is idle. The read returns the receive word as it was before the read. Transmit-enable=1 blocks every start.
- R4: `sck_o` idles high. Each bit is `HALF_DIV` cycles low and then `HALF_DIV` cycles high, and `sdi_i` is sampled on the rising edge. A transfer therefore produces one falling edge per bit.
- R5: A transfer has 8+len bits, where len is control bits 7:5. The completion edge comes (2·bits−1)·`HALF_DIV` cycles after the edge that sampled the triggering read.
- R6: With bit-order 0 (MSB first), each sampled bit enters at bit 0 and earlier bits move up. The word is right-aligned in 16 bits and the upper bits are 0.
- R7: With bit-order 1 (LSB first), the k-th sampled bit lands at bit k. The word is right-aligned and the upper bits are 0.
- R8: On the completion edge, the receive word is loaded, status busy falls and `irq_o` goes high for exactly one cycle.
- R9: Status bit 0 (address 2) reads 1 from the edge after a starting read until the completion edge.
- R10: With start-control cleared while run=1, a read of address 1 returns the last word and starts nothing. No clock edges and no interrupt follow, and a repeated read returns the same word.
- R11: `sdo_o` is constant low.
- R12: A read of address 1 during a transfer neither restarts nor lengthens it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| addr_i | input | 2 | register address: 0 control, 1 receive word, 2 status |
| wr_i | input | 1 | write strobe |
| rd_i | input | 1 | read strobe; the read data is combinational |
| wdata_i | input | 8 | control write data |
| rdata_o | output | 16 | read data |
| sck_o | output | 1 | serial clock, idles high |
| sdi_i | input | 1 | serial data in |
| sdo_o | output | 1 | serial data out, held low |
| irq_o | output | 1 | one-cycle reception-complete pulse |

## Verification
Random 16-bit bit streams are received under two directed settings and four random settings, covering both bit orders and lengths from 8 to 15 bits.
- **Bit order:** a reversed order or a misplaced alignment gives a visibly different word.
- **Length:** measuring completion time and counting clock edges separates the 8-bit case from the 15-bit case.
- **Stream control:** each batch of three chained transfers shows that a trigger read returns the previous word.
- **Stray reads:** a read during a transfer must change neither the word nor the timing.
- **Blocked starts:** cleared start-control, transmit-enable set and run cleared are each tried, and each must produce no serial activity.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int DATA_W    = 16;
  localparam int LEN_W     = 3;
  localparam int BASE_BITS = 8;
  localparam int ADDR_W    = 2;
  localparam int CTRL_W    = 5 + LEN_W;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RX   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             lsb_first;
    logic             go;
    logic             tx_en;
    logic             rx_en;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/rxm_regs.sv
module rxm_regs
  import rxm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              busy_i,
  output ctrl_t             ctrl_o
);
  ctrl_t             ctrl_q;
  ctrl_t             wr_val;
  logic [DATA_W-1:0] rx_q;

  assign wr_val = ctrl_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i && addr_i == ADDR_CTRL) begin
      ctrl_q.run <= wr_val.run;
      ctrl_q.go  <= wr_val.go;
      if (!ctrl_q.run) begin
        ctrl_q.rx_en     <= wr_val.rx_en;
        ctrl_q.tx_en     <= wr_val.tx_en;
        ctrl_q.lsb_first <= wr_val.lsb_first;
        ctrl_q.len       <= wr_val.len;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rx_q <= '0;
    else if (!ctrl_q.run) rx_q <= '0;
    else if (load_i)      rx_q <= word_i;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_RX:   rdata_o = rx_q;
      ADDR_STAT: rdata_o = {{(DATA_W-1){1'b0}}, busy_i};
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;

  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_CTRL && ctrl_q.run) |=>
      $stable({ctrl_q.len, ctrl_q.lsb_first, ctrl_q.tx_en, ctrl_q.rx_en}));
endmodule

// File: rtl/rxm_clkgen.sv
module rxm_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  input  logic active_i,
  output logic sck_o,
  output logic rise_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] hcnt_q;
  logic          sck_q;
  logic          wrap;

  assign wrap   = (hcnt_q == LAST);
  assign rise_o = active_i && !sck_q && wrap;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b1;
      hcnt_q <= '0;
    end else if (clr_i) begin
      sck_q  <= 1'b1;
      hcnt_q <= '0;
    end else if (start_i) begin
      sck_q  <= 1'b0;
      hcnt_q <= '0;
    end else if (active_i) begin
      if (wrap) begin
        hcnt_q <= '0;
        sck_q  <= ~sck_q;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  // R4
  half_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q <= LAST);
endmodule

// File: rtl/rxm_shifter.sv
module rxm_shifter #(
  parameter int DW    = 16,
  parameter int LW    = 3,
  parameter int BASE  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          rise_i,
  input  logic          sdi_i,
  input  logic          lsb_first_i,
  input  logic [LW-1:0] len_i,
  output logic          done_o,
  output logic [DW-1:0] word_o
);
  localparam int BCW = $clog2(DW + 1);

  logic [DW-1:0]  sh_q, sh_nxt;
  logic [BCW-1:0] cnt_q, n_bits, shamt;

  assign n_bits = BCW'(BASE) + BCW'(len_i);
  assign shamt  = BCW'(DW) - n_bits;
  assign done_o = rise_i && (cnt_q == n_bits - 1'b1);

  always_comb begin
    if (lsb_first_i) begin
      sh_nxt = {sdi_i, sh_q[DW-1:1]};
      word_o = sh_nxt >> shamt;
    end else begin
      sh_nxt = {sh_q[DW-2:0], sdi_i};
      word_o = sh_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i || start_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (rise_i) begin
      sh_q  <= sh_nxt;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R5
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < n_bits);
endmodule

// File: rtl/rxm_top.sv
module rxm_top
  import rxm_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic              busy_q, irq_q, start, done, rise, clr, rx_rd;
  logic [DATA_W-1:0] word;

  assign clr   = !ctrl.run;
  assign rx_rd = rd_i && addr_i == ADDR_RX;
  assign start = rx_rd && ctrl.run && ctrl.rx_en && !ctrl.tx_en && ctrl.go && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= done && !clr;
      if (clr)        busy_q <= 1'b0;
      else if (start) busy_q <= 1'b1;
      else if (done)  busy_q <= 1'b0;
    end
  end

  rxm_regs i_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .rdata_o,
    .load_i (done),
    .word_i (word),
    .busy_i (busy_q),
    .ctrl_o (ctrl)
  );

  rxm_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
    .clk_i, .rst_ni,
    .clr_i    (clr),
    .start_i  (start),
    .active_i (busy_q),
    .sck_o,
    .rise_o   (rise)
  );

  rxm_shifter #(.DW(DATA_W), .LW(LEN_W), .BASE(BASE_BITS)) i_shifter (
    .clk_i, .rst_ni,
    .clr_i       (clr),
    .start_i     (start),
    .rise_i      (rise),
    .sdi_i,
    .lsb_first_i (ctrl.lsb_first),
    .len_i       (ctrl.len),
    .done_o      (done),
    .word_o      (word)
  );

  assign sdo_o = 1'b0;
  assign irq_o = irq_q;

  // R4
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> sck_o);
  // R8
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R8
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!busy_q && $past(busy_q)));
  // R1
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run |=> !busy_q);
  // R12
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rx_rd && !done && ctrl.run) |=> busy_q);
endmodule

// File: tb/test_rxm_top.sv
`timescale 1ns/100ps
module test_rxm_top;
  localparam int H = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, sdi = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] rdata;
  logic        sck, sdo, irq;

  int n_chk = 0, n_bad = 0, cyc = 0, bit_idx = 0;
  int sck_falls = 0, irq_cnt = 0, sdo_hi = 0;
  logic [15:0] stream = '0;

  rxm_top #(.HALF_DIV(H)) i_rxm_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .sdi_i(sdi),
    .sdo_o(sdo), .irq_o(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (irq === 1'b1) irq_cnt++;
    if (sdo !== 1'b0) sdo_hi++;
  end
  // slave model: present next bit after each falling clock edge
  always @(negedge sck) begin
    sck_falls++;
    sdi = stream[bit_idx];
    if (bit_idx < 15) bit_idx++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #0.5 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  function automatic logic [7:0] mk(bit run, bit rxe, bit txe, bit go, bit lsb, logic [2:0] len);
    return {len, lsb, go, txe, rxe, run};
  endfunction

  function automatic logic [15:0] exp_word(logic [15:0] s, int n, bit lsb);
    logic [15:0] r = '0;
    for (int k = 0; k < n; k++)
      if (lsb) r[k] = s[k]; else r[n-1-k] = s[k];
    return r;
  endfunction

  task automatic wait_quiet(input int cycles, input string req);
    int f0 = sck_falls, i0 = irq_cnt;
    logic [15:0] st;
    repeat (cycles) @(negedge clk);
    check({req, " no clock edges"}, sck_falls - f0, 0);
    check({req, " no irq"}, irq_cnt - i0, 0);
    rd_reg(2'd2, st);
    check({req, " idle status"}, st, 16'h0);
    check({req, " sck high"}, sck, 1'b1);
  endtask

  task automatic launch(input logic [15:0] s, output logic [15:0] v, output int c0, output int f0);
    stream = s; bit_idx = 0;
    f0 = sck_falls;
    rd_reg(2'd1, v);
    c0 = cyc;
  endtask

  task automatic wait_irq(input int c0, input int f0, input int n);
    int guard = 0;
    while (irq !== 1'b1 && guard < 400) begin @(negedge clk); guard++; end
    check("R5 completion time", cyc - c0, (2*n-1)*H);
    check("R4 one falling edge per bit", sck_falls - f0, n);
    @(negedge clk);
    check("R8 irq single cycle", irq, 1'b0);
  endtask

  initial begin
    logic [15:0] v, e, s;
    int c0, f0, n;
    bit lsb;
    logic [2:0] len;
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_reg(2'd0, v); check("R1 ctrl after reset", v, 16'h0);
    rd_reg(2'd2, v); check("R1 status after reset", v, 16'h0);
    rd_reg(2'd1, v); check("R1 rx after reset", v, 16'h0);
    check("R1 sck idle", sck, 1'b1);
    check("R8 irq low after reset", irq, 1'b0);

    // R1 run=0 read starts nothing
    wr_reg(2'd0, mk(0,1,0,1,0,3'd0));
    rd_reg(2'd1, v);
    wait_quiet(10, "R1");

    // R3 tx enable blocks start
    wr_reg(2'd0, mk(1,1,1,1,0,3'd0));
    rd_reg(2'd1, v);
    wait_quiet(10, "R3 tx_en");
    wr_reg(2'd0, mk(0,1,1,1,0,3'd0));

    for (int b = 0; b < 6; b++) begin
      if (b == 0)      begin len = 3'd0; lsb = 1'b0; end
      else if (b == 1) begin len = 3'd7; lsb = 1'b1; end
      else             begin len = 3'($urandom_range(0, 7)); lsb = 1'($urandom_range(0, 1)); end
      n = 8 + int'(len);
      wr_reg(2'd0, mk(0,1,0,1,lsb,len));
      wr_reg(2'd0, mk(1,1,0,1,lsb,len));
      if (b == 0) begin
        wr_reg(2'd0, mk(1,0,1,1,~lsb,len ^ 3'd1));
        rd_reg(2'd0, v);
        check("R2 mode locked while running", v, {8'h0, mk(1,1,0,1,lsb,len)});
      end
      s = 16'($urandom);
      launch(s, v, c0, f0);
      check("R3 dummy read returns prior word", v, 16'h0);
      rd_reg(2'd2, v);
      check("R9 busy during transfer", v, 16'h1);
      for (int t = 0; t < 3; t++) begin
        wait_irq(c0, f0, n);
        e = exp_word(s, n, lsb);
        if (t == 2) begin
          wr_reg(2'd0, mk(1,1,0,0,lsb,len));
          rd_reg(2'd1, v);
          check(lsb ? "R10 R7 final word" : "R10 R6 final word", v, e);
          wait_quiet(12, "R10");
          rd_reg(2'd1, v);
          check("R10 repeat read", v, e);
        end else begin
          s = 16'($urandom);
          launch(s, v, c0, f0);
          check(lsb ? "R7 lsb-first word" : "R6 msb-first word", v, e);
          if (t == 0) begin
            rd_reg(2'd1, v);
            check("R12 read mid-transfer keeps word", v, e);
          end
        end
      end
      rd_reg(2'd2, v);
      check("R9 idle before stop", v, 16'h0);
      wr_reg(2'd0, mk(0,1,0,1,lsb,len));
      rd_reg(2'd1, v);
      check("R1 rx cleared when stopped", v, 16'h0);
    end

    check("R11 sdo held low", sdo_hi, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule